// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory Reader

This block models the read side of a bit-serial, nonvolatile configuration store that an FPGA clocks out in master serial mode. The FPGA drives the serial clock and two control lines: a chip enable and one shared pin that acts as both pointer reset and output enable. On every clock edge the block advances an internal bit pointer through a fixed array and presents the next stored bit on a data line that can be tri-stated.

A static configuration bit sets the meaning of the shared pin. In one setting a high level resets the pointer and a low level enables the output. In the other setting a low level resets and a high level enables.

When the last stored bit has been shifted out, the block releases the data line and pulls its enable-out low. The next device in a daisy chain, whose chip enable is wired to that output, then takes over the shared data line. If the pointer is never reset, it keeps its position across standby periods. A later configuration pass therefore continues at the following stored bit.

Top module: `cfgRomReader`

## Requirements
- R1: `dataDrive` is 1 only while chip enable is active (`chipEnN` = 0), output enable is active, and the pointer has not passed the last bit. Otherwise it is 0, which means the data line is released.
- R2: With `resetHigh` = 1, `rstOePin` = 1 means reset and `rstOePin` = 0 means output enable. With `resetHigh` = 0, the pin meanings are swapped.
- R3: On each rising clock edge where chip enable and output enable are both active, and the array is not exhausted, the pointer rises by one. `dataOut` always presents the stored bit at the current pointer.
- R4: A rising clock edge that sees the reset level on the shared pin clears the pointer to 0. This also applies while in standby.
- R5: While `chipEnN` = 1 (standby), the pointer does not advance and `dataDrive` = 0, whatever level the shared pin has.
- R6: After the clock edge that moves past the last stored bit, `cascadeOutN` is 0 and `dataDrive` is 0.
- R7: At the end of the array, `cascadeOutN` stays 0 exactly while chip enable and output enable are both active. It returns to 1 as soon as either becomes inactive.
- R8: Once exhausted, the pointer saturates and never wraps to the first bit without a reset.
- R9: `porN` = 0 clears the pointer. Without a later reset, the pointer is retained through standby, and reading resumes at the next stored bit.
- R10: Stored bit k is bit (k mod 32) of word k/32 (bits within a word go out LSB first). Word i holds ((i+1)·0x9E3779B9 mod 2^32) XOR 0x5A3C96E1. The array holds WORDS such words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the configuring FPGA |
| porN | input | 1 | Power-on reset, active low |
| chipEnN | input | 1 | Chip enable, active low; high selects standby |
| rstOePin | input | 1 | Shared reset / output-enable pin |
| resetHigh | input | 1 | Polarity select: 1 = pin high resets |
| dataOut | output | 1 | Current stored bit |
| dataDrive | output | 1 | Drive enable for `dataOut`; 0 means high impedance |
| cascadeOutN | output | 1 | Enable-out to the next device, active low |

## Verification
A full read of a small two-word array is done under each pin polarity. This separates correct bit order and content from an off-by-one in the pointer or in the end-of-array detection. After the end is reached, extra clocks are applied, and chip enable and output enable are each dropped and restored. This shows the difference between a pointer that saturates and one that wraps, and between an enable-out that follows the enables and one that latches. Standby is then entered part way through a read, once with the pin at its enable level and once at its reset level. The first case shows that the pointer is retained, and the second shows that reset still works in standby.

// File: rtl/cfgRomPkg.sv
`timescale 1ns/100ps
package cfgRomPkg;

  localparam int WORD_W = 32;

  // Strobes the control block hands to the datapath each cycle.
  typedef struct packed {
    logic clearPtr;
    logic stepPtr;
  } ctrlStrobes_t;

  // Stored word content, derived arithmetically from the word index.
  function automatic logic [WORD_W-1:0] romWord(input int unsigned idx);
    logic [WORD_W-1:0] prod;
    prod = WORD_W'((idx + 1) * 32'h9E37_79B9);
    return prod ^ 32'h5A3C_96E1;
  endfunction

endpackage

// File: rtl/cfgRomCtrl.sv
`timescale 1ns/100ps
module cfgRomCtrl
  import cfgRomPkg::*;
(
  input  logic         chipEnN,
  input  logic         rstOePin,
  input  logic         resetHigh,
  input  logic         atEnd,
  output ctrlStrobes_t strobes,
  output logic         dataDrive,
  output logic         cascadeOutN
);

  logic resetActive;
  logic oeActive;
  logic ceActive;

  // Polarity decode of the shared pin.
  always_comb begin
    if (resetHigh) begin
      resetActive = rstOePin;
      oeActive    = ~rstOePin;
    end else begin
      resetActive = ~rstOePin;
      oeActive    = rstOePin;
    end
  end

  assign ceActive = ~chipEnN;

  always_comb begin
    strobes.clearPtr = resetActive;
    strobes.stepPtr  = ceActive & oeActive & ~atEnd;
  end

  assign dataDrive   = ceActive & oeActive & ~atEnd;
  assign cascadeOutN = ~(ceActive & oeActive & atEnd);

endmodule

// File: rtl/cfgRomDatapath.sv
`timescale 1ns/100ps
module cfgRomDatapath
  import cfgRomPkg::*;
#(
  parameter int WORDS = 4,
  localparam int TOTAL_BITS = WORDS * WORD_W,
  localparam int IDX_W = $clog2(TOTAL_BITS),
  localparam int PTR_W = $clog2(TOTAL_BITS + 1)
) (
  input  logic             clk,
  input  logic             porN,
  input  ctrlStrobes_t     strobes,
  output logic [PTR_W-1:0] bitPtr,
  output logic             atEnd,
  output logic             dataBit
);

  logic [TOTAL_BITS-1:0] romBits;

  // Array contents fixed at elaboration, one word per generate pass.
  for (genvar w = 0; w < WORDS; w++) begin : gWord
    assign romBits[w*WORD_W +: WORD_W] = romWord(w);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      bitPtr <= '0;
    end else if (strobes.clearPtr) begin
      bitPtr <= '0;
    end else if (strobes.stepPtr) begin
      bitPtr <= bitPtr + PTR_W'(1);
    end
  end

  assign atEnd   = (bitPtr == PTR_W'(TOTAL_BITS));
  assign dataBit = atEnd ? 1'b0 : romBits[bitPtr[IDX_W-1:0]];

endmodule

// File: rtl/cfgRomReader.sv
`timescale 1ns/100ps
module cfgRomReader
  import cfgRomPkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic clk,
  input  logic porN,
  input  logic chipEnN,
  input  logic rstOePin,
  input  logic resetHigh,
  output logic dataOut,
  output logic dataDrive,
  output logic cascadeOutN
);

  localparam int TOTAL_BITS = WORDS * WORD_W;
  localparam int PTR_W = $clog2(TOTAL_BITS + 1);

  ctrlStrobes_t     strobes;
  logic [PTR_W-1:0] bitPtr;
  logic             atEnd;

  cfgRomCtrl ctrlInst (
    .chipEnN     (chipEnN),
    .rstOePin    (rstOePin),
    .resetHigh   (resetHigh),
    .atEnd       (atEnd),
    .strobes     (strobes),
    .dataDrive   (dataDrive),
    .cascadeOutN (cascadeOutN)
  );

  cfgRomDatapath #(.WORDS(WORDS)) dpInst (
    .clk     (clk),
    .porN    (porN),
    .strobes (strobes),
    .bitPtr  (bitPtr),
    .atEnd   (atEnd),
    .dataBit (dataOut)
  );

endmodule

// File: rtl/cfgRomReader_chk.sv
`timescale 1ns/100ps
module cfgRomReader_chk #(
  parameter int TOTAL_BITS = 128,
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             porN,
  input logic             chipEnN,
  input logic             rstOePin,
  input logic             resetHigh,
  input logic             dataDrive,
  input logic             cascadeOutN,
  input logic [PTR_W-1:0] bitPtr
);

  logic rstLvl;
  logic oeLvl;
  assign rstLvl = (rstOePin == resetHigh);
  assign oeLvl  = ~rstLvl;

  assert_drive_gated_R1: assert property (@(posedge clk) disable iff (!porN)
    dataDrive |-> (!chipEnN && oeLvl));

  assert_reset_clears_R4: assert property (@(posedge clk) disable iff (!porN)
    rstLvl |=> (bitPtr == '0));

  assert_standby_holds_R5: assert property (@(posedge clk) disable iff (!porN)
    (chipEnN && oeLvl) |=> $stable(bitPtr));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!porN)
    (!chipEnN && oeLvl && bitPtr < PTR_W'(TOTAL_BITS)) |=> (bitPtr == $past(bitPtr) + PTR_W'(1)));

  assert_handoff_exclusive_R6: assert property (@(posedge clk) disable iff (!porN)
    !cascadeOutN |-> !dataDrive);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!porN)
    (bitPtr == PTR_W'(TOTAL_BITS) && oeLvl) |=> (bitPtr == PTR_W'(TOTAL_BITS)));

  assert_ptr_bounded_R8: assert property (@(posedge clk) disable iff (!porN)
    bitPtr <= PTR_W'(TOTAL_BITS));

endmodule

bind cfgRomReader cfgRomReader_chk #(.TOTAL_BITS(TOTAL_BITS), .PTR_W(PTR_W)) chkInst (
  .clk         (clk),
  .porN        (porN),
  .chipEnN     (chipEnN),
  .rstOePin    (rstOePin),
  .resetHigh   (resetHigh),
  .dataDrive   (dataDrive),
  .cascadeOutN (cascadeOutN),
  .bitPtr      (bitPtr)
);

// File: tb/cfgRomReader_test.sv
`timescale 1ns/100ps
module cfgRomReader_test;

  localparam int WORDS = 2;
  localparam int NBITS = WORDS * 32;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic chipEnN = 1'b1;
  logic rstOePin = 1'b0;
  logic resetHigh = 1'b1;
  logic dataOut, dataDrive, cascadeOutN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  cfgRomReader #(.WORDS(WORDS)) uut (
    .clk(clk), .porN(porN), .chipEnN(chipEnN), .rstOePin(rstOePin),
    .resetHigh(resetHigh), .dataOut(dataOut), .dataDrive(dataDrive),
    .cascadeOutN(cascadeOutN)
  );

  // R10: expected stored bit from the stated word formula.
  function automatic logic expBit(input int k);
    logic [31:0] w;
    w = 32'((k / 32 + 1) * 32'h9E37_79B9) ^ 32'h5A3C_96E1;
    return w[k % 32];
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2: pin level computed from the wanted reset state and the polarity bit.
  task automatic setPins(input logic ceOn, input logic rstOn);
    chipEnN  = ~ceOn;
    rstOePin = resetHigh ? rstOn : ~rstOn;
    #0.5;
  endtask

  task automatic readRun(input int start, input int count, input string req);
    for (int i = 0; i < count; i++) begin
      check(req, "dataOut", dataOut, expBit(start + i));
      check(req, "dataDrive", dataDrive, 1'b1);
      check(req, "cascadeOutN", cascadeOutN, 1'b1);
      tick();
    end
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    setPins(1'b1, 1'b0);
    repeat (3) tick();
    porN = 1'b1;
    #0.5;
    // R9: power-on reset leaves pointer at bit 0
    check("R9", "dataDrive after por", dataDrive, 1'b1);
    check("R9", "dataOut after por", dataOut, expBit(0));
    check("R9", "cascadeOutN after por", cascadeOutN, 1'b1);

    for (int pol = 0; pol < 2; pol++) begin
      resetHigh = pol[0];
      setPins(1'b1, 1'b1);
      check("R2", "dataDrive with reset level", dataDrive, 1'b0);
      check("R1", "cascadeOutN with reset level", cascadeOutN, 1'b1);
      tick();
      setPins(1'b1, 1'b0);
      check("R2", "dataDrive with enable level", dataDrive, 1'b1);
      readRun(0, NBITS, "R3");
      check("R6", "dataDrive at end", dataDrive, 1'b0);
      check("R6", "cascadeOutN at end", cascadeOutN, 1'b0);
      repeat (3) tick();
      check("R8", "dataDrive after extra clocks", dataDrive, 1'b0);
      check("R8", "cascadeOutN after extra clocks", cascadeOutN, 1'b0);
      setPins(1'b0, 1'b0);
      check("R7", "cascadeOutN chip disabled", cascadeOutN, 1'b1);
      check("R5", "dataDrive chip disabled", dataDrive, 1'b0);
      tick();
      setPins(1'b1, 1'b0);
      check("R7", "cascadeOutN re-enabled at end", cascadeOutN, 1'b0);
      check("R8", "dataDrive re-enabled at end", dataDrive, 1'b0);
      setPins(1'b1, 1'b1);
      check("R7", "cascadeOutN output disabled", cascadeOutN, 1'b1);
      tick();
      setPins(1'b1, 1'b0);
      check("R4", "dataOut after pin reset", dataOut, expBit(0));
      check("R4", "dataDrive after pin reset", dataDrive, 1'b1);
    end

    // Standby part way through with the pin at enable level: pointer retained
    readRun(0, 10, "R10");
    setPins(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check("R5", "dataDrive in standby", dataDrive, 1'b0);
      tick();
    end
    setPins(1'b1, 1'b0);
    readRun(10, 5, "R9");

    // Standby with the pin at reset level: drive stays off, pointer cleared
    setPins(1'b0, 1'b1);
    check("R5", "dataDrive standby reset level", dataDrive, 1'b0);
    tick();
    setPins(1'b0, 1'b0);
    check("R5", "dataDrive standby enable level", dataDrive, 1'b0);
    tick();
    setPins(1'b1, 1'b0);
    check("R4", "dataOut after standby reset", dataOut, expBit(0));
    readRun(0, 40, "R10");

    finishRun();
  end

endmodule